// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer with a 16-bit register interface. Software writes a control word that sets a timeout in half-second steps and turns the timer on. From then on a down-counter, driven by a prescaled tick, runs toward zero. Software keeps the system alive by writing a fixed two-word key to the service register. Only the complete key, in the correct order, reloads the counter.

If the counter reaches zero, the block drives an active-high reset request for a fixed number of clock cycles. It records in a status register that the watchdog caused the reset, and then stays halted until the system reset arrives. Two gating inputs, one for debug halt and one for low power, can freeze the countdown. Each acts only when its control bit allows it.

The block takes two resets. A power-on reset clears everything. A system reset clears the timer and control state but keeps the reset-cause record. Both resets are asserted asynchronously and released synchronously inside the block.

Top module: `wdk_top`

## Requirements
- R1: Registers sit at byte offsets 0 (control), 2 (service) and 4 (status), selected by the full `bus_addr`. After power-on reset, control reads 0x0000, and service and unmapped offsets always read 0x0000.
- R2: Writing control with bit 2 (enable) set while the timer is off loads the counter with WT+1, where WT is bits 15:8 of the written word. With no service and no freeze, `wdog_rst_o` first reads high (WT+1)×TICK_DIV clock edges after the edge of that write.
- R3: A service write of 0x5555 followed by a service write of 0xAAAA reloads the counter at the edge of the 0xAAAA write, so expiry follows (WT+1)×TICK_DIV edges after it. Service writes while the timer is off start nothing.
- R4: When the key is pending, any service write other than 0xAAAA cancels it, including a second 0x5555. A later 0xAAAA then does not reload the counter.
- R5: Writes to the control or status register between the two key words do not cancel a pending key.
- R6: Once set, the enable bit stays set until the next system reset, even if control is written with bit 2 clear. Such a write does not reload the counter.
- R7: At expiry, `wdog_rst_o` is high for exactly RST_CYCLES consecutive cycles.
- R8: After expiry the counter stays halted. No further reset request occurs before the next system reset, even if a full service key is written.
- R9: Status bit 0 means the last reset was power-on, and bit 1 means the watchdog expired. Expiry sets bit 1 and clears bit 0. A system reset keeps both bits. A power-on reset sets bit 0 and clears bit 1. Writes to status have no effect.
- R10: While control bit 1 is set and `dbg_halt` is high, or control bit 0 is set and `low_power` is high, the countdown is frozen. Without the matching control bit, the input has no effect.
- R11: Control bits 15:8, 7, 4, 3, 1 and 0 are stored and read back as written. Bits 6 and 5 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| rst_n | input | 1 | System reset, active low, asynchronous assert |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| dbg_halt | input | 1 | Debug halt indication |
| low_power | input | 1 | Low-power indication |
| wdog_rst_o | output | 1 | Reset request, active high |

## Verification
The assertions assume the bus is synchronous to `clk`, and that each access lasts one cycle with stable address and data. They also assume that power-on reset is never released while the system reset keeps the block held, and that no power-on reset lands inside a reset-request pulse. The bench drives every bus field and gating input at the falling edge and holds it for one whole cycle. It applies the two resets only between scenarios, after any pulse has ended, so these assumptions always hold.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_SVC  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd4;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_SECOND = 16'hAAAA;

  localparam int CB_LP_FRZ  = 0;
  localparam int CB_DBG_FRZ = 1;
  localparam int CB_EN      = 2;
  localparam int WT_LSB     = 8;

  localparam logic [DATA_W-1:0] CTRL_KEEP = 16'hFF9F;

  typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_e;
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
#(
  parameter int WT_W = 8
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              por_rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              expire,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              en_rise,
  output logic [WT_W-1:0]   wt_next,
  output logic              svc_ok,
  output logic [1:0]        stat_q
);
  logic              ctrl_wr, svc_wr;
  logic [DATA_W-1:0] ctrl_d;
  key_state_e        key_q, key_d;
  logic [1:0]        stat_d;

  assign ctrl_wr = bus_sel && bus_we && (bus_addr == OFS_CTRL);
  assign svc_wr  = bus_sel && bus_we && (bus_addr == OFS_SVC);

  // control next state; enable is sticky
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d = bus_wdata & CTRL_KEEP;
      ctrl_d[CB_EN] = ctrl_q[CB_EN] | bus_wdata[CB_EN];
    end
  end

  assign en_rise = ctrl_wr && bus_wdata[CB_EN] && !ctrl_q[CB_EN];
  assign wt_next = ctrl_d[WT_LSB +: WT_W];

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  // key sequence tracker
  always_comb begin
    key_d  = key_q;
    svc_ok = 1'b0;
    if (svc_wr) begin
      if (key_q == KEY_IDLE) begin
        key_d = (bus_wdata == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
      end else begin
        svc_ok = (bus_wdata == KEY_SECOND);
        key_d  = KEY_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) key_q <= KEY_IDLE;
    else if (svc_wr) key_q <= key_d;
  end

  // reset cause: bit0 power-on, bit1 watchdog
  always_comb begin
    stat_d = stat_q;
    if (expire) stat_d = 2'b10;
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) stat_q <= 2'b01;
    else if (expire) stat_q <= stat_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      unique case (bus_addr)
        OFS_CTRL: bus_rdata = ctrl_q;
        OFS_STAT: bus_rdata = {{(DATA_W-2){1'b0}}, stat_q};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdk_prescaler.sv
module wdk_prescaler #(
  parameter int TICK_DIV = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] div_q, div_d;

  assign tick = run && !clr && (div_q == LAST);

  always_comb begin
    div_d = div_q;
    if (clr)       div_d = '0;
    else if (tick) div_d = '0;
    else if (run)  div_d = div_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (clr || run) div_q <= div_d;
  end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int WT_W       = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [WT_W-1:0] wt_val,
  input  logic            tick,
  output logic [WT_W:0]   cnt_q,
  output logic            expire,
  output logic            expired_q,
  output logic            wdog_rst_o
);
  localparam int CNT_W = WT_W + 1;
  localparam int RC_W  = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_d;
  logic             do_load;
  logic [RC_W-1:0]  pulse_q, pulse_d;

  assign do_load = load && !expired_q;
  assign expire  = tick && !do_load && !expired_q && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (do_load)
      cnt_d = CNT_W'(wt_val) + CNT_W'(1);
    else if (tick && !expired_q && (cnt_q != '0))
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_comb begin
    pulse_d = pulse_q;
    if (expire)              pulse_d = RC_W'(RST_CYCLES);
    else if (pulse_q != '0)  pulse_d = pulse_q - RC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
      pulse_q   <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (expire) expired_q <= 1'b1;
      pulse_q <= pulse_d;
    end
  end

  assign wdog_rst_o = (pulse_q != '0);
endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
#(
  parameter int TICK_DIV    = 16384,
  parameter int WT_W        = 8,
  parameter int RST_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        dbg_halt,
  input  logic        low_power,
  output logic        wdog_rst_o
);
  logic                   sys_arst_n;
  logic [SYNC_STAGES-1:0] por_sync_q, sys_sync_q;
  logic                   por_rst_n, sys_rst_n;

  assign sys_arst_n = por_n & rst_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) por_sync_q <= '0;
    else        por_sync_q <= {por_sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge sys_arst_n) begin
    if (!sys_arst_n) sys_sync_q <= '0;
    else             sys_sync_q <= {sys_sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign por_rst_n = por_sync_q[SYNC_STAGES-1];
  assign sys_rst_n = sys_sync_q[SYNC_STAGES-1];

  logic [DATA_W-1:0] ctrl_q;
  logic              en_rise, svc_ok, load, tick, run, frozen;
  logic [WT_W-1:0]   wt_next;
  logic [1:0]        stat_q;
  logic [WT_W:0]     cnt_q;
  logic              expire, expired_q;

  wdk_regs #(.WT_W(WT_W)) regs_i (
    .clk(clk), .sys_rst_n(sys_rst_n), .por_rst_n(por_rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .expire(expire), .bus_rdata(bus_rdata),
    .ctrl_q(ctrl_q), .en_rise(en_rise), .wt_next(wt_next),
    .svc_ok(svc_ok), .stat_q(stat_q)
  );

  assign frozen = (ctrl_q[CB_DBG_FRZ] && dbg_halt) ||
                  (ctrl_q[CB_LP_FRZ]  && low_power);
  assign load   = en_rise || (svc_ok && ctrl_q[CB_EN]);
  assign run    = ctrl_q[CB_EN] && !expired_q && !frozen && (cnt_q != '0);

  wdk_prescaler #(.TICK_DIV(TICK_DIV)) presc_i (
    .clk(clk), .rst_n(sys_rst_n), .run(run), .clr(load), .tick(tick)
  );

  wdk_counter #(.WT_W(WT_W), .RST_CYCLES(RST_CYCLES)) cnt_i (
    .clk(clk), .rst_n(sys_rst_n), .load(load), .wt_val(wt_next),
    .tick(tick), .cnt_q(cnt_q), .expire(expire),
    .expired_q(expired_q), .wdog_rst_o(wdog_rst_o)
  );
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
  parameter int WT_W       = 8,
  parameter int RST_CYCLES = 16
) (
  input logic            clk,
  input logic            sys_rst_n,
  input logic            wdog_rst_o,
  input logic            ctrl_en,
  input logic            load,
  input logic            expire,
  input logic            expired_q,
  input logic            frozen,
  input logic [WT_W:0]   cnt_q,
  input logic [WT_W-1:0] wt_next,
  input logic [1:0]      stat_q
);
  int unsigned pulse_len;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)      pulse_len <= 0;
    else if (wdog_rst_o) pulse_len <= pulse_len + 1;
    else                 pulse_len <= 0;
  end

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!sys_rst_n)
    ctrl_en |=> ctrl_en); // R6
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (load && !expired_q) |=> (cnt_q == ($past({1'b0, wt_next}) + 1'b1))); // R3
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!sys_rst_n)
    pulse_len <= RST_CYCLES); // R7
  AST_CAUSE_RECORDED: assert property (@(posedge clk) disable iff (!sys_rst_n)
    wdog_rst_o |-> (stat_q == 2'b10)); // R9
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (frozen && !load) |=> $stable(cnt_q)); // R10
  AST_HALT_AFTER: assert property (@(posedge clk) disable iff (!sys_rst_n)
    expired_q |=> (expired_q && $stable(cnt_q))); // R8
  AST_SINGLE_EXPIRY: assert property (@(posedge clk) disable iff (!sys_rst_n)
    expired_q |-> !expire); // R8
  AST_EXPIRY_NEEDS_EN: assert property (@(posedge clk) disable iff (!sys_rst_n)
    expire |-> ctrl_en); // R2
endmodule

bind wdk_top wdk_checker #(.WT_W(WT_W), .RST_CYCLES(RST_CYCLES)) chk_i (
  .clk(clk), .sys_rst_n(sys_rst_n), .wdog_rst_o(wdog_rst_o),
  .ctrl_en(ctrl_q[2]), .load(load), .expire(expire),
  .expired_q(expired_q), .frozen(frozen), .cnt_q(cnt_q),
  .wt_next(wt_next), .stat_q(stat_q)
);

// File: tb/wdk_top_tb_top.sv
module wdk_top_tb_top;
  localparam int DIV = 4;
  localparam int RC  = 3;

  logic        clk = 1'b0;
  logic        por_n, rst_n, bus_sel, bus_we, dbg_halt, low_power;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        wdog_rst_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdk_top #(.TICK_DIV(DIV), .RST_CYCLES(RC)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dbg_halt(dbg_halt), .low_power(low_power),
    .wdog_rst_o(wdog_rst_o)
  );

  // rows: written control, expected readback, expected edges to expiry
  localparam logic [15:0] V_WR[4] = '{16'h0004, 16'h0107, 16'h0304, 16'h05FC};
  localparam logic [15:0] V_RD[4] = '{16'h0004, 16'h0107, 16'h0304, 16'h059C};
  localparam int          V_N[4]  = '{4, 8, 16, 24};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = int'(bus_rdata);
    bus_sel = 0;
  endtask

  task automatic do_por();
    por_n = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_sysrst();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  // counts edges until the reset request is seen; releases freeze inputs at rel
  task automatic measure(input int rel, output int n);
    n = 0;
    while (n < 600) begin
      @(negedge clk);
      n++;
      if (n == rel) begin dbg_halt = 0; low_power = 0; end
      if (wdog_rst_o) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog timeout");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d, n, len;
    por_n = 0; rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = 0;
    bus_wdata = 0; dbg_halt = 0; low_power = 0;
    do_por();

    // R1 reset state
    rd(3'd0, d); check("R1 ctrl reset", d, 0);
    rd(3'd2, d); check("R1 svc reads 0", d, 0);
    rd(3'd6, d); check("R1 unmapped reads 0", d, 0);
    rd(3'd4, d); check("R9 status after por", d, 1);
    check("R1 no reset out", int'(wdog_rst_o), 0);

    // R3 key while disabled starts nothing
    wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
    measure(0, n); check("R3 disabled no expiry", n, 600);

    // table of timeouts
    for (int i = 0; i < 4; i++) begin
      do_por();
      wr(3'd0, V_WR[i]);
      rd(3'd0, d); check("R11 ctrl readback", d, int'(V_RD[i]));
      measure(0, n); check("R2 timeout edges", n, V_N[i]);
      len = 1;
      while (len < 50) begin @(negedge clk); if (!wdog_rst_o) break; len++; end
      check("R7 pulse length", len, RC);
      if (i == 0) begin
        rd(3'd4, d); check("R9 status after expiry", d, 2);
        wr(3'd4, 16'hFFFF);
        rd(3'd4, d); check("R9 status write ignored", d, 2);
        wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
        measure(0, n); check("R8 halted after expiry", n, 600);
        do_sysrst();
        rd(3'd4, d); check("R9 status kept on sys reset", d, 2);
        rd(3'd0, d); check("R6 enable cleared by reset", d, 0);
        do_por();
        rd(3'd4, d); check("R9 status after new por", d, 1);
      end
    end

    // R3 service reload
    do_por(); wr(3'd0, 16'h0104);
    repeat (5) @(negedge clk);
    wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
    measure(0, n); check("R3 reload by key", n, 8);

    // R4 wrong word aborts
    do_por(); wr(3'd0, 16'h0104);
    wr(3'd2, 16'h5555); wr(3'd2, 16'h1234); wr(3'd2, 16'hAAAA);
    measure(0, n); check("R4 bad word aborts", n, 5);
    do_por(); wr(3'd0, 16'h0104);
    wr(3'd2, 16'h5555); wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
    measure(0, n); check("R4 repeated first word aborts", n, 5);

    // R5 other registers between keys
    do_por(); wr(3'd0, 16'h0104);
    wr(3'd2, 16'h5555); wr(3'd4, 16'h0000); wr(3'd2, 16'hAAAA);
    measure(0, n); check("R5 status write keeps key", n, 8);

    // R6 enable write-once
    do_por(); wr(3'd0, 16'h0104); wr(3'd0, 16'h0100);
    rd(3'd0, d); check("R6 enable sticky", d, 16'h0104);
    measure(0, n); check("R6 no reload on rewrite", n, 7);

    // R10 freeze gating
    do_por(); dbg_halt = 1; wr(3'd0, 16'h0106);
    measure(20, n); check("R10 debug freeze", n, 28);
    do_por(); low_power = 1; wr(3'd0, 16'h0105);
    measure(20, n); check("R10 low-power freeze", n, 28);
    do_por(); low_power = 1; dbg_halt = 1; wr(3'd0, 16'h0104);
    measure(100, n); check("R10 ungated inputs ignored", n, 8);
    dbg_halt = 0; low_power = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule